// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block gathers interrupt requests from a bank of external pins for a small processor core. Each pin passes through a synchronizer. A per-pin sense code, supplied from outside the block, selects what counts as an event on that pin: a rising edge, a falling edge, any change, or a low level. Edge-type events latch into a flag register. The controller also keeps an enable mask, and both registers are reached through a single-address-bit read/write port.

A channel is pending when its flag is set, or when it is in level mode and its pin is held low. The controller raises one request line when any pending channel is enabled and the global enable input is high. It reports the lowest-numbered such channel as the vector index. When the core takes that vector, it pulses the acknowledge input, which clears the flag of the reported channel only.

Pins are sampled regardless of the direction of their pads. Software can therefore raise an interrupt by toggling a pin that it drives itself.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the mask register and the flag register both read 0, `irq_o` is 0 and `vec_o` is 0.
- R2: With `reg_addr_i` = 0 the port addresses the mask register, and with `reg_addr_i` = 1 it addresses the flag register. `reg_rdata_o` shows the addressed register combinationally. A write to the mask register takes effect on the clock edge where `reg_we_i` is high.
- R3: The sense code of channel i is `sense_i[2i+1:2i]`: 00 selects low level, 01 any change, 10 falling edge and 11 rising edge. A qualifying edge on a pin sets that channel's flag three clock edges after the pin changes, whatever the mask bit. No other transition sets the flag.
- R4: Writing the flag register clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R5: An acknowledge pulse while `irq_o` is high clears only the flag of the channel shown on `vec_o`.
- R6: While a channel's sense code is 00, its flag reads as 0 at once and stays 0. The channel is pending for as long as its synchronized pin is low.
- R7: `irq_o` is 1 exactly when `gie_i` is 1 and at least one pending channel has its mask bit set.
- R8: When several enabled channels are pending, `vec_o` gives the lowest-numbered one.
- R9: When a flag-setting event and a write-one-to-clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | External pin levels (asynchronous) |
| sense_i | input | 16 | Two-bit sense code per channel |
| gie_i | input | 1 | Global interrupt enable from the core |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = mask register, 1 = flag register |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| ack_i | input | 1 | Core has taken the reported vector |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 3 | Index of the highest-priority pending channel |

## Verification
A flag that is stuck or wrongly cleared shows on `reg_rdata_o` in the very cycle that follows. With the channel's mask bit and the global enable set, it also shows on `irq_o` and `vec_o`. A wrong synchronizer or edge history moves a flag set by one cycle or misses it entirely, so checks are placed exactly three edges after each pin change. A fault in the priority or acknowledge logic appears as the wrong channel on `vec_o` right after an acknowledge, or as a flag left set or cleared on the following read.

// File: rtl/eic_pkg.sv
package eic_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam logic REG_MASK = 1'b0;
    localparam logic REG_FLAG = 1'b1;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int N_CH   = 8,
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pin_i,
    output logic [N_CH-1:0] lvl_o
);
    logic [STAGES-1:0][N_CH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{{N_CH{RST_VAL}}}};
        else        chain_q <= chain_d;
    end

    assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/eic_detect.sv
module eic_detect
    import eic_pkg::*;
#(
    parameter int N_CH = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   lvl_i,
    input  logic [2*N_CH-1:0] sense_i,
    output logic [N_CH-1:0]   evt_o,
    output logic [N_CH-1:0]   low_req_o,
    output logic [N_CH-1:0]   is_level_o
);
    logic [N_CH-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= {N_CH{RST_VAL}};
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        sense_e mode;
        assign mode = sense_e'(sense_i[2*g +: 2]);
        always_comb begin
            evt_o[g]      = 1'b0;
            low_req_o[g]  = 1'b0;
            is_level_o[g] = 1'b0;
            unique case (mode)
                SENSE_LOW: begin
                    is_level_o[g] = 1'b1;
                    low_req_o[g]  = ~lvl_i[g];
                end
                SENSE_ANY:  evt_o[g] = lvl_i[g] ^ prev_q[g];
                SENSE_FALL: evt_o[g] = prev_q[g] & ~lvl_i[g];
                SENSE_RISE: evt_o[g] = ~prev_q[g] & lvl_i[g];
                default:    evt_o[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/eic_prio.sv
module eic_prio #(
    parameter int N_CH = 8,
    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pend_i,
    output logic            any_o,
    output logic [IW-1:0]   idx_o
);
    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IW'(i);
        end
    end

    // R8: nothing below the reported index is pending
    a_r8_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (pend_i[idx_o] && ((pend_i & ((N_CH'(1) << idx_o) - N_CH'(1))) == '0)));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   pin_i,
    input  logic [2*N_CH-1:0] sense_i,
    input  logic              gie_i,
    input  logic              reg_we_i,
    input  logic              reg_addr_i,
    input  logic [N_CH-1:0]   reg_wdata_i,
    output logic [N_CH-1:0]   reg_rdata_o,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [IW-1:0]     vec_o
);
    typedef struct packed {
        logic [N_CH-1:0] mask;
        logic [N_CH-1:0] flag;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    logic [N_CH-1:0] lvl, evt, low_req, is_level, pend, clr;
    logic            any_pend;

    eic_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .lvl_o(lvl)
    );

    eic_detect #(.N_CH(N_CH), .RST_VAL(1'b1)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .sense_i(sense_i),
        .evt_o(evt), .low_req_o(low_req), .is_level_o(is_level)
    );

    assign pend = (ctrl_q.flag | low_req) & ctrl_q.mask;

    eic_prio #(.N_CH(N_CH)) u_prio (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .any_o(any_pend), .idx_o(vec_o)
    );

    assign irq_o       = gie_i & any_pend;
    assign reg_rdata_o = (reg_addr_i == REG_FLAG) ? (ctrl_q.flag & ~is_level) : ctrl_q.mask;

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_we_i && reg_addr_i == REG_MASK) ctrl_d.mask = reg_wdata_i;
        for (int i = 0; i < N_CH; i++) begin
            clr[i] = (reg_we_i && reg_addr_i == REG_FLAG && reg_wdata_i[i])
                   || (ack_i && irq_o && vec_o == IW'(i));
            if (is_level[i])  ctrl_d.flag[i] = 1'b0;
            else if (evt[i])  ctrl_d.flag[i] = 1'b1;
            else if (clr[i])  ctrl_d.flag[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // R3: an edge event always lands in the flag register
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((ctrl_q.flag & $past(evt)) == $past(evt)));

    // R4: written ones clear flags that saw no event
    a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == REG_FLAG) |=>
        ((ctrl_q.flag & $past(reg_wdata_i & ~evt)) == '0));

    // R5: acknowledge clears the reported channel
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !evt[vec_o]) |=> !ctrl_q.flag[$past(vec_o)]);

    // R6: level-mode channels hold no flag
    a_r6_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (|is_level) |=> ((ctrl_q.flag & $past(is_level)) == '0));

    // R7: request only with the global enable
    a_r7_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> !irq_o);
endmodule

// File: tb/tb_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '1;
    logic [2*N-1:0] sense = '0;
    logic         gie = 1'b0, we = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;
    logic [2:0]   vec;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_i(sense), .gie_i(gie),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ack_i(ack), .irq_o(irq), .vec_o(vec)
    );

    // entry: {mode[1:0], from, to, expect, ch[2:0]}
    localparam logic [7:0] VECS [8] = '{
        {2'b11, 1'b0, 1'b1, 1'b1, 3'd0},
        {2'b11, 1'b1, 1'b0, 1'b0, 3'd1},
        {2'b10, 1'b1, 1'b0, 1'b1, 3'd2},
        {2'b10, 1'b0, 1'b1, 1'b0, 3'd3},
        {2'b01, 1'b0, 1'b1, 1'b1, 3'd4},
        {2'b01, 1'b1, 1'b0, 1'b1, 3'd5},
        {2'b01, 1'b1, 1'b1, 1'b0, 3'd6},
        {2'b11, 1'b1, 1'b1, 1'b0, 3'd7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [N-1:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [N-1:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic all_mode(input logic [1:0] m);
        for (int i = 0; i < N; i++) sense[2*i +: 2] = m;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        all_mode(2'b10);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, d); check("R1 mask", d, 0);
        rd(1'b1, d); check("R1 flag", d, 0);
        check("R1 irq", irq, 0);
        check("R1 vec", vec, 0);

        // R3 table, mask left at zero
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            e = VECS[k];
            all_mode(e[7:6]);
            pin[e[2:0]] = e[5];
            settle();
            wr(1'b1, '1);
            @(negedge clk); pin[e[2:0]] = e[4];
            settle();
            rd(1'b1, d);
            check("R3 sense table", d, 32'(e[3]) << e[2:0]);
            pin = '1; settle(); wr(1'b1, '1);
        end

        // R3 exact latency: flag appears on the third edge
        all_mode(2'b10); wr(1'b1, '1);
        @(negedge clk); pin[0] = 1'b0; addr = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R3 not before third edge", rdata, 0);
        @(posedge clk); #1;
        check("R3 third edge", rdata, 8'h01);
        pin = '1; settle(); wr(1'b1, '1);

        // R2 mask access
        wr(1'b0, 8'hA5);
        rd(1'b0, d); check("R2 mask readback", d, 8'hA5);
        wr(1'b0, 8'h00);

        // R4 write-one-to-clear
        @(negedge clk); pin[0] = 1'b0; pin[1] = 1'b0;
        settle();
        rd(1'b1, d); check("R4 two flags set", d, 8'h03);
        wr(1'b1, 8'h00);
        rd(1'b1, d); check("R4 zero write keeps", d, 8'h03);
        wr(1'b1, 8'h01);
        rd(1'b1, d); check("R4 one clears bit0 only", d, 8'h02);

        // R7 gating
        gie = 1'b1; @(negedge clk);
        check("R7 masked off", irq, 0);
        wr(1'b0, 8'h02); gie = 1'b0; @(negedge clk);
        check("R7 gie low", irq, 0);
        gie = 1'b1; @(negedge clk);
        check("R7 request", irq, 1);
        check("R7 vec", vec, 1);

        // R8 / R5 priority and acknowledge
        @(negedge clk); pin[5] = 1'b0; settle();
        wr(1'b0, 8'hFF);
        rd(1'b1, d); check("R8 flags", d, 8'h22);
        check("R8 lowest first", vec, 1);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        rd(1'b1, d); check("R5 ack clears one", d, 8'h20);
        check("R5 next vec", vec, 5);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        rd(1'b1, d); check("R5 all clear", d, 8'h00);
        check("R5 irq drops", irq, 0);

        // R6 level mode
        @(negedge clk); pin[3] = 1'b0; settle();
        rd(1'b1, d); check("R6 edge flag before", d, 8'h08);
        sense[7:6] = 2'b00; addr = 1'b1; #1;
        check("R6 reads zero at once", rdata, 8'h00);
        @(negedge clk);
        check("R6 level request", irq, 1);
        check("R6 level vec", vec, 3);
        pin[3] = 1'b1; settle();
        check("R6 request ends", irq, 0);
        rd(1'b1, d); check("R6 flag stays zero", d, 8'h00);
        sense[7:6] = 2'b10;

        // R9 set beats clear
        wr(1'b0, 8'h00); wr(1'b1, '1);
        @(negedge clk); pin[6] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); we = 1'b1; addr = 1'b1; wdata = '1;
        @(negedge clk); we = 1'b0; wdata = '0;
        rd(1'b1, d); check("R9 set wins", d, 8'h40);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule